// File: doc/BRIEF.md
# Write-Streaming Mode Detector

This block sits beside the miss-handling logic of a write-back data cache. It watches every access the cache presents: the line address, the byte-enable mask, whether the access is a load or a store, and whether it missed. From this stream it decides whether store misses should allocate. In normal mode a store miss fetches the line first (read-for-ownership). In streaming mode a store miss skips the fill and the data goes straight out.

The detector follows one line at a time and records which of its bytes have been written. Once a number of sequentially increasing lines have each been written in full, with none of their data read in the meantime, the block switches to streaming mode. A load, a jump in the address pattern, or moving on from a line that is only partly written returns it to normal mode. The allocate decision is combinational on the current access and uses the mode held before that access. Mode changes show on `stream_mode` one clock after the access that causes them.

Top module: `wstream_detect`

## Requirements
- R1: After reset `stream_mode` is 0, no line is tracked, and the count of fully written lines is zero.
- R2: A store miss (`acc_valid`=1, `acc_write`=1, `acc_miss`=1) in normal mode asserts `miss_fill` and keeps `miss_bypass` low in the same cycle. `miss_fill` and `miss_bypass` are never high together.
- R3: A store miss while `stream_mode` is 1 asserts `miss_bypass` and keeps `miss_fill` low in the same cycle.
- R4: A load miss (`acc_write`=0) always asserts `miss_fill`, whatever the mode.
- R5: A line counts once the OR of its store byte enables is all ones (bit i of `acc_be` marks byte i of the 64-byte line). The line must be the tracked line, or the line one above a fully written tracked line. `stream_mode` rises one cycle after the store that completes the fourth such consecutive line, and not after the third.
- R6: A line filled by several partial stores, overlapping or not, counts the same as one full store.
- R7: A store to the next line while the tracked line is only partly written clears the count and leaves streaming mode.
- R8: A store to any line other than the tracked line or the line after a fully written tracked line clears the count and leaves streaming mode.
- R9: A load to the tracked line clears the count, ends tracking of that line and leaves streaming mode.
- R10: A load to any other line leaves streaming mode but keeps the count. If the count had reached four, the next completed sequential line re-enters streaming mode.
- R11: In a cycle with `acc_valid`=0 the mode, the count and the tracked line are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_line | input | LINE_AW (26) | Line address of the access |
| acc_be | input | LINE_BYTES (64) | Byte-enable mask, bit i = byte i of the line |
| acc_miss | input | 1 | The access missed in the cache |
| stream_mode | output | 1 | 1 = streaming (no-fill) mode |
| miss_fill | output | 1 | This miss must fetch the line |
| miss_bypass | output | 1 | This store miss writes out without a fill |

## Verification
The bench targets the threshold boundary. A detector off by one would enter streaming after three lines or need five. It also covers lines completed from split halves; a design that checked each mask alone would never count them. The next-line store after a half-written line is tested, where a design lacking the partial check would keep counting and stream wrongly. A load elsewhere after the threshold should leave the mode but keep the count; a design that cleared the count would need four more lines to re-enter. Randomized runs mix sequential full lines, partial writes, jumps and loads, and compare the mode and the fill decision every cycle.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    // Classification of one presented access relative to the tracked line.
    typedef enum logic [2:0] {
        EV_NONE,        // no access this cycle
        EV_SAME,        // store to the tracked line
        EV_SEQ,         // store to the next line after a complete tracked line
        EV_BREAK,       // any other store
        EV_LOAD_HIT,    // load to the tracked line
        EV_LOAD_OTHER   // load elsewhere
    } wsd_ev_e;

    function automatic logic ev_is_store(wsd_ev_e ev);
        return (ev == EV_SAME) || (ev == EV_SEQ) || (ev == EV_BREAK);
    endfunction

endpackage

// File: rtl/wsd_classify.sv
module wsd_classify
    import wsd_pkg::*;
#(
    parameter int unsigned LINE_AW = 26
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [LINE_AW-1:0] acc_line,
    input  logic               trk_valid,
    input  logic [LINE_AW-1:0] trk_line,
    input  logic               trk_full,
    output wsd_ev_e            ev
);
    localparam logic [LINE_AW-1:0] ONE = {{(LINE_AW-1){1'b0}}, 1'b1};

    logic hit_same;
    logic hit_next;

    always_comb begin
        hit_same = trk_valid && (acc_line == trk_line);
        hit_next = trk_valid && trk_full && (acc_line == (trk_line + ONE));
        if (!acc_valid) begin
            ev = EV_NONE;
        end else if (!acc_write) begin
            ev = hit_same ? EV_LOAD_HIT : EV_LOAD_OTHER;
        end else if (hit_same) begin
            ev = EV_SAME;
        end else if (hit_next) begin
            ev = EV_SEQ;
        end else begin
            ev = EV_BREAK;
        end
    end
endmodule

// File: rtl/wsd_cover.sv
module wsd_cover #(
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic [LINE_BYTES-1:0] mask_q,
    input  logic [LINE_BYTES-1:0] be,
    input  logic                  restart,
    output logic [LINE_BYTES-1:0] mask_d,
    output logic                  full_q,
    output logic                  completes
);
    logic full_d;

    always_comb begin
        mask_d    = restart ? be : (mask_q | be);
        full_q    = &mask_q;
        full_d    = &mask_d;
        // A line completes once: on the access that makes it full.
        completes = full_d && (restart || !full_q);
    end
endmodule

// File: rtl/wsd_run.sv
module wsd_run #(
    parameter int unsigned THRESH = 4,
    localparam int unsigned CNT_W = $clog2(THRESH + 1)
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt_d,
    output logic             reached
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] base;

    always_comb begin
        base    = clear ? '0 : cnt_q;
        cnt_d   = base;
        reached = 1'b0;
        if (bump) begin
            if (base != LIMIT) begin
                cnt_d = base + ONE;
            end
            reached = (cnt_d == LIMIT);
        end
    end
endmodule

// File: rtl/wstream_detect.sv
module wstream_detect
    import wsd_pkg::*;
#(
    parameter int unsigned LINE_AW    = 26,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned THRESH     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [LINE_AW-1:0]    acc_line,
    input  logic [LINE_BYTES-1:0] acc_be,
    input  logic                  acc_miss,
    output logic                  stream_mode,
    output logic                  miss_fill,
    output logic                  miss_bypass
);
    localparam int unsigned CNT_W = $clog2(THRESH + 1);

    typedef struct packed {
        logic                  trk_valid;
        logic [LINE_AW-1:0]    trk_line;
        logic [LINE_BYTES-1:0] trk_mask;
        logic [CNT_W-1:0]      run;
        logic                  stream;
    } wsd_state_t;

    wsd_state_t st_q, st_d;

    wsd_ev_e               ev;
    logic                  trk_full;
    logic [LINE_BYTES-1:0] mask_next;
    logic                  line_done;
    logic                  is_store;
    logic                  restart;
    logic                  run_clear;
    logic [CNT_W-1:0]      run_next;
    logic                  run_hit;

    wsd_classify #(.LINE_AW(LINE_AW)) u_classify (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_line  (acc_line),
        .trk_valid (st_q.trk_valid),
        .trk_line  (st_q.trk_line),
        .trk_full  (trk_full),
        .ev        (ev)
    );

    wsd_cover #(.LINE_BYTES(LINE_BYTES)) u_cover (
        .mask_q    (st_q.trk_mask),
        .be        (acc_be),
        .restart   (restart),
        .mask_d    (mask_next),
        .full_q    (trk_full),
        .completes (line_done)
    );

    wsd_run #(.THRESH(THRESH)) u_run (
        .cnt_q   (st_q.run),
        .clear   (run_clear),
        .bump    (is_store && line_done),
        .cnt_d   (run_next),
        .reached (run_hit)
    );

    always_comb begin
        is_store  = ev_is_store(ev);
        restart   = (ev == EV_SEQ) || (ev == EV_BREAK);
        run_clear = (ev == EV_BREAK) || (ev == EV_LOAD_HIT);

        st_d = st_q;
        unique case (ev)
            EV_SAME: begin
                st_d.trk_mask = mask_next;
            end
            EV_SEQ: begin
                st_d.trk_valid = 1'b1;
                st_d.trk_line  = acc_line;
                st_d.trk_mask  = mask_next;
            end
            EV_BREAK: begin
                st_d.trk_valid = 1'b1;
                st_d.trk_line  = acc_line;
                st_d.trk_mask  = mask_next;
                st_d.stream    = 1'b0;
            end
            EV_LOAD_HIT: begin
                st_d.trk_valid = 1'b0;
                st_d.trk_mask  = '0;
                st_d.stream    = 1'b0;
            end
            EV_LOAD_OTHER: begin
                st_d.stream = 1'b0;
            end
            default: begin
            end
        endcase
        st_d.run = run_next;
        if (run_hit) begin
            st_d.stream = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stream_mode = st_q.stream;
        miss_fill   = acc_valid && acc_miss && (!acc_write || !st_q.stream);
        miss_bypass = acc_valid && acc_miss && acc_write && st_q.stream;
    end
endmodule

// File: rtl/wstream_detect_chk.sv
module wstream_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_write,
    input logic acc_miss,
    input logic stream_mode,
    input logic miss_fill,
    input logic miss_bypass
);
    AST_FILL_XOR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_fill && miss_bypass)); // R2

    AST_BYPASS_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        miss_bypass |-> (stream_mode && acc_write)); // R3

    AST_LOAD_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_miss && !acc_write) |-> miss_fill); // R4

    AST_ENTRY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_mode) |-> $past(acc_valid && acc_write)); // R5

    AST_LOAD_LEAVES_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !stream_mode); // R10

    AST_IDLE_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(stream_mode)); // R11
endmodule

bind wstream_detect wstream_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_miss    (acc_miss),
    .stream_mode (stream_mode),
    .miss_fill   (miss_fill),
    .miss_bypass (miss_bypass)
);

// File: tb/tb_wstream_detect.sv
module tb_wstream_detect;
    localparam int AW = 26;
    localparam int NB = 64;
    localparam int TH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acc_valid, acc_write, acc_miss;
    logic [AW-1:0] acc_line;
    logic [NB-1:0] acc_be;
    logic          stream_mode, miss_fill, miss_bypass;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    bit          m_tv;
    bit [AW-1:0] m_line;
    bit [NB-1:0] m_mask;
    int          m_cnt;
    bit          m_stream;

    localparam bit [NB-1:0] FULL = '1;
    localparam bit [NB-1:0] LOW  = {32'h0, 32'hFFFF_FFFF};
    localparam bit [NB-1:0] HIGH = {32'hFFFF_FFFF, 32'h0};

    always #2 clk = ~clk;

    wstream_detect dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_line(acc_line), .acc_be(acc_be), .acc_miss(acc_miss),
        .stream_mode(stream_mode), .miss_fill(miss_fill), .miss_bypass(miss_bypass)
    );

    function automatic bit exp_fill(bit v, bit wr, bit miss, bit strm);
        return v && miss && (!wr || !strm);
    endfunction

    function automatic bit exp_bypass(bit v, bit wr, bit miss, bit strm);
        return v && miss && wr && strm;
    endfunction

    task automatic check(string tag, logic got, bit exp, string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic model_step(bit wr, bit [AW-1:0] ln, bit [NB-1:0] be);
        bit same, seq, was, comp;
        comp = 0;
        if (!wr) begin
            m_stream = 0;
            if (m_tv && ln == m_line) begin
                m_cnt = 0; m_tv = 0; m_mask = '0;
            end
        end else begin
            same = m_tv && (ln == m_line);
            seq  = m_tv && (ln == m_line + 1'b1) && (m_mask == FULL);
            if (same) begin
                was = (m_mask == FULL);
                m_mask = m_mask | be;
                comp = (m_mask == FULL) && !was;
            end else begin
                if (!seq) begin
                    m_cnt = 0; m_stream = 0;
                end
                m_tv = 1; m_line = ln; m_mask = be;
                comp = (be == FULL);
            end
            if (comp) begin
                if (m_cnt < TH) m_cnt++;
                if (m_cnt >= TH) m_stream = 1;
            end
        end
    endtask

    task automatic acc(string tag, bit wr, bit [AW-1:0] ln, bit [NB-1:0] be, bit miss);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_line = ln; acc_be = be; acc_miss = miss;
        #1;
        check(tag, miss_fill,   exp_fill(1, wr, miss, m_stream),   "miss_fill");
        check(tag, miss_bypass, exp_bypass(1, wr, miss, m_stream), "miss_bypass");
        @(posedge clk);
        model_step(wr, ln, be);
        #1;
        check(tag, stream_mode, m_stream, "stream_mode");
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        acc_valid = 0; acc_write = $urandom_range(1); acc_miss = 1;
        acc_line = AW'($urandom); acc_be = FULL;
        #1;
        check(tag, miss_fill, 0, "miss_fill idle");
        @(posedge clk);
        #1;
        check(tag, stream_mode, m_stream, "stream_mode idle");
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit [AW-1:0] cur;
        void'($urandom(32'h5EED_0042));
        acc_valid = 0; acc_write = 0; acc_miss = 0; acc_line = '0; acc_be = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        m_tv = 0; m_line = '0; m_mask = '0; m_cnt = 0; m_stream = 0;
        check("R1", stream_mode, 0, "stream_mode after reset");

        // R2 / R5: three complete lines stay normal, the fourth enters
        cur = 26'h100;
        acc("R2", 1, cur, FULL, 1);
        acc("R5", 1, cur + 1, FULL, 1);
        acc("R5", 1, cur + 2, FULL, 1);
        check("R5", stream_mode, 0, "no stream after three lines");
        acc("R5", 1, cur + 3, FULL, 1);
        check("R5", stream_mode, 1, "stream after fourth line");
        cur = cur + 3;
        // R3: store miss bypasses
        cur++; acc("R3", 1, cur, FULL, 1);
        // R4 / R10: load miss elsewhere fills and leaves stream
        acc("R4", 0, 26'h3_0000, FULL, 1);
        check("R10", stream_mode, 0, "load elsewhere leaves stream");
        cur++; acc("R10", 1, cur, FULL, 1);
        check("R10", stream_mode, 1, "re-entry after one more line");
        // R11: idle holds
        idle("R11"); idle("R11");
        // R6: split halves complete a line
        cur++; acc("R6", 1, cur, LOW, 1);
        acc("R6", 1, cur, HIGH, 0);
        check("R6", stream_mode, 1, "split line keeps stream");
        // R7: move on from a partial line
        cur++; acc("R7", 1, cur, LOW, 1);
        cur++; acc("R7", 1, cur, FULL, 1);
        check("R7", stream_mode, 0, "partial line breaks stream");
        for (int i = 0; i < 2; i++) begin cur++; acc("R7", 1, cur, FULL, 1); end
        check("R7", stream_mode, 0, "count restarted at one");
        cur++; acc("R7", 1, cur, FULL, 1);
        // R8: address jump
        cur = cur + 10; acc("R8", 1, cur, FULL, 1);
        check("R8", stream_mode, 0, "jump leaves stream");
        for (int i = 0; i < 2; i++) begin cur++; acc("R8", 1, cur, FULL, 1); end
        check("R8", stream_mode, 0, "count cleared by jump");
        cur++; acc("R8", 1, cur, FULL, 1);
        // R9: load to tracked line
        acc("R9", 0, cur, FULL, 0);
        check("R9", stream_mode, 0, "tracked load leaves stream");
        for (int i = 0; i < 3; i++) begin cur++; acc("R9", 1, cur, FULL, 1); end
        check("R9", stream_mode, 0, "count cleared by tracked load");
        cur++; acc("R9", 1, cur, FULL, 1);

        // randomized mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit mb;
            r  = $urandom_range(15);
            mb = $urandom_range(1);
            if (r <= 8)       begin cur++; acc("R5", 1, cur, FULL, mb); end
            else if (r <= 10) acc("R6", 1, cur, {$urandom, $urandom}, mb);
            else if (r == 11) begin cur++; acc("R7", 1, cur, {$urandom, $urandom}, mb); end
            else if (r == 12) acc("R9", 0, cur, FULL, mb);
            else if (r == 13) acc("R10", 0, AW'($urandom), FULL, mb);
            else if (r == 14) begin cur = AW'($urandom); acc("R8", 1, cur, FULL, mb); end
            else              idle("R11");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule